// File: doc/BRIEF.md
# Temperature Sensor Function-Layer Controller

This block is the command layer of a single-wire temperature sensor slave. It sits above the address-selection layer. Once that layer reports the device selected, this block takes the next received byte as a function command. It then serves a nine-byte scratchpad, moves the two alarm threshold bytes between a volatile and a nonvolatile copy, starts temperature conversions and answers the master's read slots.

The surrounding bit engine delivers whole received bytes and single read-slot requests. A bus reset from that engine ends any command at once. Two activities are modelled as timed handshakes counted in microsecond ticks: the conversion, whose result is taken from input ports when it finishes, and the nonvolatile write. After every conversion the block compares the new temperature with the stored thresholds and updates a level alarm output.

Top module: `thermo_fn_ctrl`

## Requirements
- R1: After reset the scratchpad holds temperature 00AAh (+85 °C at 0.5 °C per LSB, bytes 0 and 1 little-endian), both threshold copies hold the parameter defaults (bytes 2 = high, 3 = low), bytes 4 and 5 read FFh, byte 6 reads 0Ch, byte 7 reads 10h, and alarm_o is 0.
- R2: Scratchpad byte 8 is the CRC-8 of bytes 0–7 with polynomial x^8+x^5+x^4+1, register cleared to 0, bytes taken in address order and bits LSB first.
- R3: Command 4Eh stores the next two received bytes into addresses 2 and 3; any further bytes before a bus reset are ignored.
- R4: A bus reset after only one byte of a 4Eh write leaves address 3 unchanged, and commits nothing to nonvolatile storage.
- R5: Command BEh returns bytes 0 through 8 LSB first on successive read slots; every slot after byte 8 returns 1.
- R6: Command 44h pulses conv_start_o and starts a conversion of CONV_TICKS ticks; read slots return 0 while it runs and 1 after; at its end temp_i, cnt_remain_i and cnt_per_c_i land in bytes 0–1, 6 and 7.
- R7: Command 48h latches addresses 2 and 3 and writes them to nonvolatile storage after COPY_TICKS ticks; read slots return 0 while busy and 1 after. Nonvolatile values change in no other way.
- R8: Command B8h reloads addresses 2 and 3 from nonvolatile storage; its read slots return 0 while a conversion runs (conversions keep running across a bus reset) and 1 otherwise.
- R9: Command B4h answers every read slot with ext_pwr_i (0 = powered from the data line, 1 = external supply).
- R10: At the end of each conversion alarm_o is set when bits 8:1 of the result, as a signed byte, exceed the nonvolatile high threshold or fall below the nonvolatile low threshold, and cleared otherwise; volatile threshold edits without a copy do not affect it.
- R11: Bytes received while the device is not selected are ignored.
- R12: An unrecognised command byte makes every read slot return 1 until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low (power-up) |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| sel_i | input | 1 | Address layer reports the device selected |
| bus_rst_i | input | 1 | Bus reset seen; ends the current command |
| rx_valid_i | input | 1 | A received byte is present |
| rx_byte_i | input | 8 | Received byte |
| slot_req_i | input | 1 | Master opened a read slot |
| tx_bit_o | output | 1 | Bit to return in the most recent read slot |
| ext_pwr_i | input | 1 | External supply present |
| conv_start_o | output | 1 | Pulse: conversion started |
| temp_i | input | 16 | Conversion result, sign-extended, 0.5 °C per LSB |
| cnt_remain_i | input | 8 | Remaining-count result |
| cnt_per_c_i | input | 8 | Count-per-degree result |
| alarm_o | output | 1 | Alarm flag from the last conversion |

## Verification
The bench sweeps the conversion result across every half-degree step around a positive high and negative low threshold. A compare that kept the half-degree bit, compared unsigned, or used the volatile copies would flag the wrong steps, and each step also re-checks the trailing CRC against a bench-side shift model. It targets the read tail beyond byte 8, a bus reset between the two write bytes, a recall with no copy in between, and a recall issued while a conversion started before a bus reset is still running. A design that restarted the address, committed partial writes or dropped the conversion at bus reset returns wrong bytes or wrong busy bits there.

// File: rtl/thermo_fn_pkg.sv
package thermo_fn_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_WRITE, ST_READ, ST_CONV, ST_COPY, ST_RECALL, ST_PWR, ST_HOLD
  } fn_state_e;

  localparam logic [7:0] OP_WR_SP  = 8'h4E;
  localparam logic [7:0] OP_RD_SP  = 8'hBE;
  localparam logic [7:0] OP_COPY   = 8'h48;
  localparam logic [7:0] OP_CONV   = 8'h44;
  localparam logic [7:0] OP_RECALL = 8'hB8;
  localparam logic [7:0] OP_PWR    = 8'hB4;

  localparam logic [15:0] TEMP_POR   = 16'h00AA;
  localparam logic [7:0]  REMAIN_POR = 8'h0C;
  localparam logic [7:0]  PERC_POR   = 8'h10;
  localparam logic [7:0]  RSVD_BYTE  = 8'hFF;
endpackage

// File: rtl/sp_crc8.sv
module sp_crc8 #(
  parameter int NBYTES = 8,
  localparam int NBITS = NBYTES * 8
) (
  input  logic [NBITS-1:0] data_i,
  output logic [7:0]       crc_o
);
  logic [7:0] chain [NBITS+1];
  assign chain[0] = 8'h00;

  for (genvar g = 0; g < NBITS; g++) begin : g_stage
    logic fb;
    assign fb = chain[g][0] ^ data_i[g];
    // reflected x^8+x^5+x^4+1
    assign chain[g+1] = {fb, chain[g][7:1]} ^ {4'b0000, fb, fb, 2'b00};
  end

  assign crc_o = chain[NBITS];
endmodule

// File: rtl/op_timer.sv
module op_timer #(
  parameter int unsigned TICKS = 1000,
  localparam int CW = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q  <= CW'(TICKS);
        busy_o <= 1'b1;
      end else if (busy_o && tick_i) begin
        if (cnt_q <= CW'(1)) begin
          cnt_q  <= '0;
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/temp_alarm_cmp.sv
module temp_alarm_cmp (
  input  logic [15:0] temp_i,
  input  logic [7:0]  hi_i,
  input  logic [7:0]  lo_i,
  output logic        hit_o
);
  logic signed [7:0] whole;
  assign whole = $signed(temp_i[8:1]);  // half-degree bit dropped
  assign hit_o = (whole > $signed(hi_i)) || (whole < $signed(lo_i));
endmodule

// File: rtl/thermo_fn_ctrl.sv
module thermo_fn_ctrl
  import thermo_fn_pkg::*;
#(
  parameter int unsigned CONV_TICKS = 750000,
  parameter int unsigned COPY_TICKS = 10000,
  parameter logic [7:0]  NV_HI_INIT = 8'h4B,
  parameter logic [7:0]  NV_LO_INIT = 8'h46
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        sel_i,
  input  logic        bus_rst_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        slot_req_i,
  output logic        tx_bit_o,
  input  logic        ext_pwr_i,
  output logic        conv_start_o,
  input  logic [15:0] temp_i,
  input  logic [7:0]  cnt_remain_i,
  input  logic [7:0]  cnt_per_c_i,
  output logic        alarm_o
);
  localparam int SP_BYTES = 8;
  localparam int ADDR_W   = $clog2(SP_BYTES + 2);
  localparam logic [ADDR_W-1:0] CRC_ADDR = ADDR_W'(SP_BYTES);

  fn_state_e         state;
  logic              wr_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic [2:0]        rd_bit;
  logic [15:0]       temp_q;
  logic [7:0]        remain_q, perc_q;
  logic [7:0]        sp_hi, sp_lo, nv_hi, nv_lo, pend_hi, pend_lo;
  logic              conv_busy, conv_done, copy_busy, copy_done;
  logic              alarm_hit;
  logic [7:0]        crc_byte, cur_byte;
  logic [SP_BYTES*8-1:0] sp_image;
  logic              cmd_byte, conv_go, copy_go, rd_done, reply;

  assign sp_image = {perc_q, remain_q, RSVD_BYTE, RSVD_BYTE, sp_lo, sp_hi, temp_q};

  sp_crc8 #(.NBYTES(SP_BYTES)) u_crc (.data_i(sp_image), .crc_o(crc_byte));

  temp_alarm_cmp u_cmp (.temp_i(temp_i), .hi_i(nv_hi), .lo_i(nv_lo), .hit_o(alarm_hit));

  op_timer #(.TICKS(CONV_TICKS)) u_conv_tmr (
    .clk_i, .rst_ni, .start_i(conv_go), .tick_i, .busy_o(conv_busy), .done_o(conv_done)
  );

  op_timer #(.TICKS(COPY_TICKS)) u_copy_tmr (
    .clk_i, .rst_ni, .start_i(copy_go), .tick_i, .busy_o(copy_busy), .done_o(copy_done)
  );

  // command byte accepted only when no reset/select overrides it
  assign cmd_byte = (state == ST_CMD) && rx_valid_i && !bus_rst_i && !sel_i;
  assign conv_go  = cmd_byte && (rx_byte_i == OP_CONV);
  assign copy_go  = cmd_byte && (rx_byte_i == OP_COPY);
  assign rd_done  = rd_addr > CRC_ADDR;

  always_comb begin
    if (rd_addr == CRC_ADDR) cur_byte = crc_byte;
    else                     cur_byte = sp_image[rd_addr[2:0]*8 +: 8];
  end

  always_comb begin
    unique case (state)
      ST_READ:              reply = rd_done ? 1'b1 : cur_byte[rd_bit];
      ST_CONV, ST_RECALL:   reply = ~conv_busy;
      ST_COPY:              reply = ~copy_busy;
      ST_PWR:               reply = ext_pwr_i;
      default:              reply = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_IDLE;
      wr_idx       <= 1'b0;
      rd_addr      <= '0;
      rd_bit       <= '0;
      tx_bit_o     <= 1'b1;
      conv_start_o <= 1'b0;
      temp_q       <= TEMP_POR;
      remain_q     <= REMAIN_POR;
      perc_q       <= PERC_POR;
      sp_hi        <= NV_HI_INIT;
      sp_lo        <= NV_LO_INIT;
      nv_hi        <= NV_HI_INIT;
      nv_lo        <= NV_LO_INIT;
      pend_hi      <= NV_HI_INIT;
      pend_lo      <= NV_LO_INIT;
      alarm_o      <= 1'b0;
    end else begin
      conv_start_o <= conv_go;

      if (conv_done) begin
        temp_q   <= temp_i;
        remain_q <= cnt_remain_i;
        perc_q   <= cnt_per_c_i;
        alarm_o  <= alarm_hit;
      end

      if (copy_done) begin
        nv_hi <= pend_hi;
        nv_lo <= pend_lo;
      end

      if (slot_req_i) begin
        tx_bit_o <= reply;
        if (state == ST_READ && !rd_done) begin
          rd_bit <= rd_bit + 3'd1;
          if (rd_bit == 3'd7) rd_addr <= rd_addr + ADDR_W'(1);
        end
      end

      if (bus_rst_i) begin
        state <= ST_IDLE;
      end else if (sel_i) begin
        state <= ST_CMD;
      end else if (rx_valid_i) begin
        unique case (state)
          ST_CMD: begin
            unique case (rx_byte_i)
              OP_WR_SP: begin
                state  <= ST_WRITE;
                wr_idx <= 1'b0;
              end
              OP_RD_SP: begin
                state   <= ST_READ;
                rd_addr <= '0;
                rd_bit  <= '0;
              end
              OP_CONV: state <= ST_CONV;
              OP_COPY: begin
                state   <= ST_COPY;
                pend_hi <= sp_hi;
                pend_lo <= sp_lo;
              end
              OP_RECALL: begin
                state <= ST_RECALL;
                sp_hi <= nv_hi;
                sp_lo <= nv_lo;
              end
              OP_PWR:  state <= ST_PWR;
              default: state <= ST_HOLD;
            endcase
          end
          ST_WRITE: begin
            if (!wr_idx) begin
              sp_hi  <= rx_byte_i;
              wr_idx <= 1'b1;
            end else begin
              sp_lo <= rx_byte_i;
              state <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/thermo_fn_chk.sv
module thermo_fn_chk
  import thermo_fn_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input fn_state_e   state,
  input logic        slot_req_i,
  input logic        ext_pwr_i,
  input logic        tx_bit_o,
  input logic [3:0]  rd_addr,
  input logic        conv_start_o,
  input logic        conv_busy,
  input logic        conv_done,
  input logic        copy_done,
  input logic [7:0]  nv_hi,
  input logic [7:0]  nv_lo,
  input logic        alarm_o,
  input logic [15:0] temp_q
);
  // R6
  conv_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> conv_busy);

  // R6
  temp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_q != $past(temp_q)) |-> $past(conv_done));

  // R10
  alarm_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o != $past(alarm_o)) |-> $past(conv_done));

  // R7
  nv_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nv_hi != $past(nv_hi)) || (nv_lo != $past(nv_lo))) |-> $past(copy_done));

  // R5
  rd_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_req_i && state == ST_READ && rd_addr > 4'd8) |=> tx_bit_o);

  // R9
  pwr_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_req_i && state == ST_PWR) |=> (tx_bit_o == $past(ext_pwr_i)));
endmodule

bind thermo_fn_ctrl thermo_fn_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state        (state),
  .slot_req_i   (slot_req_i),
  .ext_pwr_i    (ext_pwr_i),
  .tx_bit_o     (tx_bit_o),
  .rd_addr      (rd_addr),
  .conv_start_o (conv_start_o),
  .conv_busy    (conv_busy),
  .conv_done    (conv_done),
  .copy_done    (copy_done),
  .nv_hi        (nv_hi),
  .nv_lo        (nv_lo),
  .alarm_o      (alarm_o),
  .temp_q       (temp_q)
);

// File: tb/tb_thermo_fn_ctrl.sv
`timescale 1ns/1ps
module tb_thermo_fn_ctrl;
  localparam int unsigned CONV_T = 10;
  localparam int unsigned COPY_T = 6;
  localparam logic [7:0]  HI0 = 8'h4B;
  localparam logic [7:0]  LO0 = 8'h46;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, sel_i = 1'b0, bus_rst_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic slot_req_i = 1'b0, ext_pwr_i = 1'b0;
  logic [15:0] temp_i = 16'h0000;
  logic [7:0] cnt_remain_i = 8'h00, cnt_per_c_i = 8'h00;
  logic tx_bit_o, conv_start_o, alarm_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  thermo_fn_ctrl #(.CONV_TICKS(CONV_T), .COPY_TICKS(COPY_T), .NV_HI_INIT(HI0), .NV_LO_INIT(LO0)) dut (
    .clk_i(clk), .rst_ni, .tick_i, .sel_i, .bus_rst_i, .rx_valid_i, .rx_byte_i,
    .slot_req_i, .tx_bit_o, .ext_pwr_i, .conv_start_o, .temp_i, .cnt_remain_i,
    .cnt_per_c_i, .alarm_o
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_sel();
    @(negedge clk); sel_i = 1'b1; @(negedge clk); sel_i = 1'b0;
  endtask

  task automatic bus_reset();
    @(negedge clk); bus_rst_i = 1'b1; @(negedge clk); bus_rst_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk); rx_valid_i = 1'b0;
  endtask

  task automatic start_cmd(input logic [7:0] op);
    bus_reset(); pulse_sel(); send(op);
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); slot_req_i = 1'b1;
    @(negedge clk); slot_req_i = 1'b0; b = tx_bit_o;
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      logic b;
      read_bit(b);
      v[k] = b;
    end
  endtask

  // poll until a 1 is returned; count the zeros
  task automatic poll_ready(output int zeros);
    logic b;
    zeros = 0;
    for (int i = 0; i < 400; i++) begin
      read_bit(b);
      if (b) break;
      zeros++;
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [63:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 64; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic read_sp(output logic [7:0] sp [9]);
    start_cmd(8'hBE);
    for (int i = 0; i < 9; i++) read_byte(sp[i]);
  endtask

  initial begin
    logic [7:0] sp [9];
    logic [7:0] exp_b [9];
    logic [63:0] img;
    logic [7:0] v;
    logic b;
    int zeros, t8, all1;
    bit exp_al;

    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 crc, R5 tail
    chk(alarm_o == 1'b0, "R1 alarm after reset", alarm_o, 0);
    read_sp(sp);
    exp_b[0] = 8'hAA; exp_b[1] = 8'h00; exp_b[2] = HI0; exp_b[3] = LO0;
    exp_b[4] = 8'hFF; exp_b[5] = 8'hFF; exp_b[6] = 8'h0C; exp_b[7] = 8'h10;
    for (int i = 0; i < 8; i++) img[i*8 +: 8] = exp_b[i];
    exp_b[8] = crc_ref(img);
    for (int i = 0; i < 8; i++) chk(sp[i] == exp_b[i], "R1 reset scratchpad byte", sp[i], exp_b[i]);
    chk(sp[8] == exp_b[8], "R2 reset crc", sp[8], exp_b[8]);
    read_byte(v);
    chk(v == 8'hFF, "R5 slots after byte 8", v, 8'hFF);

    // R11 bytes while unselected
    bus_reset(); send(8'h4E); send(8'h11); send(8'h22);
    read_sp(sp);
    chk(sp[2] == HI0 && sp[3] == LO0, "R11 unselected write ignored", {sp[2], sp[3]}, {HI0, LO0});

    // R3 write with extra byte ignored
    start_cmd(8'h4E); send(8'h05); send(8'hFD); send(8'h77);
    read_sp(sp);
    chk(sp[2] == 8'h05 && sp[3] == 8'hFD, "R3 write two bytes", {sp[2], sp[3]}, 16'h05FD);
    img = {sp[7], sp[6], sp[5], sp[4], sp[3], sp[2], sp[1], sp[0]};
    chk(sp[8] == crc_ref(img), "R2 crc after write", sp[8], crc_ref(img));

    // R8 recall while idle, R7 nothing committed without copy
    start_cmd(8'hB8); read_bit(b);
    chk(b == 1'b1, "R8 recall idle reports ready", b, 1);
    read_sp(sp);
    chk(sp[2] == HI0 && sp[3] == LO0, "R7 recall without copy", {sp[2], sp[3]}, {HI0, LO0});

    // R4 partial write cut by bus reset
    start_cmd(8'h4E); send(8'h33);
    read_sp(sp);
    chk(sp[2] == 8'h33 && sp[3] == LO0, "R4 partial write", {sp[2], sp[3]}, {8'h33, LO0});
    start_cmd(8'hB8);
    read_sp(sp);
    chk(sp[2] == HI0 && sp[3] == LO0, "R4 no commit of partial write", {sp[2], sp[3]}, {HI0, LO0});

    // R7 copy with busy status
    start_cmd(8'h4E); send(8'h05); send(8'hFD);
    start_cmd(8'h48);
    poll_ready(zeros);
    chk(zeros >= int'(COPY_T) && zeros <= int'(COPY_T) * 4, "R7 copy busy zeros", zeros, COPY_T);
    start_cmd(8'h4E); send(8'h11); send(8'h22);
    start_cmd(8'hB8);
    read_sp(sp);
    chk(sp[2] == 8'h05 && sp[3] == 8'hFD, "R7 recall after copy", {sp[2], sp[3]}, 16'h05FD);

    // R9 power mode
    for (int p = 0; p < 2; p++) begin
      ext_pwr_i = p[0];
      start_cmd(8'hB4);
      for (int k = 0; k < 3; k++) begin
        read_bit(b);
        chk(b == p[0], "R9 power reply", b, p);
      end
    end

    // R12 unknown command
    start_cmd(8'h99);
    all1 = 1;
    for (int k = 0; k < 8; k++) begin
      read_bit(b);
      if (!b) all1 = 0;
    end
    chk(all1 == 1, "R12 unknown command replies ones", all1, 1);

    // R6 R10 R2 sweep: nv high 05h, nv low FDh (-3)
    for (int h = -16; h <= 16; h++) begin
      temp_i = 16'(h);
      cnt_remain_i = 8'(h + 40);
      cnt_per_c_i = 8'(h * 3);
      start_cmd(8'h44);
      poll_ready(zeros);
      chk(zeros >= int'(CONV_T) && zeros <= int'(CONV_T) * 4, "R6 conversion busy zeros", zeros, CONV_T);
      repeat (3) @(negedge clk);
      t8 = h >>> 1;
      exp_al = (t8 > 5) || (t8 < -3);
      chk(alarm_o == exp_al, "R10 alarm compare", alarm_o, exp_al);
      read_sp(sp);
      chk({sp[1], sp[0]} == 16'(h) && sp[6] == 8'(h + 40) && sp[7] == 8'(h * 3),
          "R6 result captured", {sp[1], sp[0]}, 16'(h));
      img = {sp[7], sp[6], sp[5], sp[4], sp[3], sp[2], sp[1], sp[0]};
      chk(sp[8] == crc_ref(img), "R2 crc over sweep", sp[8], crc_ref(img));
    end

    // R10 volatile edit without copy does not move the thresholds
    start_cmd(8'h4E); send(8'h7F); send(8'h80);
    temp_i = 16'd16;
    start_cmd(8'h44);
    poll_ready(zeros);
    repeat (3) @(negedge clk);
    chk(alarm_o == 1'b1, "R10 uses nonvolatile thresholds", alarm_o, 1);

    // R8 recall during a conversion that survives bus reset
    temp_i = 16'd2;
    start_cmd(8'h44);
    start_cmd(8'hB8);
    read_bit(b);
    chk(b == 1'b0, "R8 recall reports converter busy", b, 0);
    poll_ready(zeros);
    chk(zeros > 0 && zeros <= int'(CONV_T) * 4, "R8 recall later reports ready", zeros, CONV_T);
    repeat (3) @(negedge clk);
    chk(alarm_o == 1'b0, "R10 alarm cleared in range", alarm_o, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule